// File: doc/BRIEF.md
# Cursor Register Port with Pattern-RAM Streaming Loader

This block sits between a byte-wide host port and the cursor hardware of a video output stage. The host sees eight direct byte registers. Two of them are live: an index register and a data register. The index register selects an entry in an indirect register space, and accesses to the data register then read or write that entry. The indirect space holds the following:

- cursor control
- a 12-bit X and Y cursor position
- a 6-bit hotspot origin
- two 24-bit cursor colours
- an address pair and a streaming data port for a 1024-byte cursor pattern RAM

The RAM array lives outside the block. The block drives its write strobe, read strobe, address and write data, and returns the RAM's read data to the host. Each access through the streaming port advances the RAM pointer by one, so software sets the address once and then moves a whole pattern with back-to-back data accesses. The register contents are presented as plain outputs to the pixel pipeline.

Top module: `curport_host_if`

## Requirements
- R1: After reset every indirect register, the index register and the RAM pointer are zero, and `host_rd_valid`, `cram_we` and `cram_re` are low.
- R2: Direct slot {host_hi_sel, host_addr} 3'b100 is the index register and 3'b101 is the data register. The six other slots read 0x00, and writes to them change nothing.
- R3: The index register keeps all 8 written bits and reads them back unchanged.
- R4: A data-register access reads or writes the indirect entry selected by the index. The map is: 0x00/0x01 X low/high, 0x02/0x03 Y low/high, 0x04/0x05 hotspot X/Y, 0x06 control, 0x08-0x0A colour 0 R,G,B, 0x0B-0x0D colour 1 R,G,B, 0x10/0x11 RAM address low/high, 0x12 RAM data port, 0xFF identity.
- R5: X and Y are 12 bits. The low entry holds bits 7:0 and the high entry holds bits 11:8 in data bits 3:0. The high entry reads back with bits 7:4 zero.
- R6: The hotspot entries hold 0..63. A written value above 63 is stored as 63.
- R7: In the control entry, bit 0 is the sprite enable and bit 7 is planar access. The other bits read as zero.
- R8: The two colours are held as 8-bit red, green and blue entries and are presented as {R,G,B} on `col0_rgb` and `col1_rgb`.
- R9: Writing address low sets pointer bits 7:0, and writing address high sets pointer bits 9:8 from data bits 1:0. Either write leaves the pointer at the newly written address. Reads of the two entries return the current pointer bits.
- R10: A data-port write raises `cram_we` in that same cycle with `cram_addr` equal to the pointer and `cram_wdata` equal to the host byte. The pointer then increments and wraps from 1023 to 0.
- R11: A data-port read raises `cram_re`, returns `cram_rdata` as sampled in the access cycle, and increments the pointer.
- R12: Indirect indices outside the map read 0x00, and writes to them are ignored. Index 0xFF reads the constant ID_VALUE (default 0x5A) and ignores writes.
- R13: Read data and `host_rd_valid` appear in the cycle after a read access. `host_rd_valid` lasts one cycle, and `host_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_hi_sel | input | 1 | Selects the upper group of four direct registers |
| host_addr | input | 2 | Direct register select within the group |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_rd_valid | output | 1 | host_rdata updated this cycle |
| cram_we | output | 1 | Pattern RAM write strobe |
| cram_re | output | 1 | Pattern RAM read strobe |
| cram_addr | output | 10 | Pattern RAM address (streaming pointer) |
| cram_wdata | output | 8 | Pattern RAM write byte |
| cram_rdata | input | 8 | Pattern RAM read byte, combinational from cram_addr |
| cur_enable | output | 1 | Sprite enable |
| cur_planar | output | 1 | Planar access select |
| cur_x | output | 12 | Cursor X position |
| cur_y | output | 12 | Cursor Y position |
| hot_x | output | 6 | Hotspot X origin |
| hot_y | output | 6 | Hotspot Y origin |
| col0_rgb | output | 24 | Colour 0 {R,G,B} |
| col1_rgb | output | 24 | Colour 1 {R,G,B} |

## Verification
The assertions assume the following about the inputs:

- Every host access lasts exactly one cycle.
- `host_we` and the address are meaningful only while `host_cs` is high.
- The pattern RAM returns `cram_rdata` combinationally from `cram_addr`.

The bench drives each access on a falling edge and lowers `host_cs` on the next falling edge. It models the RAM as a bench-side array with asynchronous read, which keeps it within those assumptions. Indirect entries are always reached by writing the index first, so no data access is made with an index that the stimulus has not set itself.

// File: rtl/curport_pkg.sv
package curport_pkg;

    typedef logic [7:0] byte_t;

    // indirect index map
    localparam byte_t IX_XLO  = 8'h00;
    localparam byte_t IX_XHI  = 8'h01;
    localparam byte_t IX_YLO  = 8'h02;
    localparam byte_t IX_YHI  = 8'h03;
    localparam byte_t IX_HOTX = 8'h04;
    localparam byte_t IX_HOTY = 8'h05;
    localparam byte_t IX_CTRL = 8'h06;
    localparam byte_t IX_C0R  = 8'h08;
    localparam byte_t IX_RAL  = 8'h10;
    localparam byte_t IX_RAH  = 8'h11;
    localparam byte_t IX_RDAT = 8'h12;
    localparam byte_t IX_ID   = 8'hFF;

    localparam int NUM_COLOUR_BYTES = 6;

    // control entry bit positions
    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_PLANAR_BIT = 7;

    typedef enum logic [1:0] {
        DSEL_NONE  = 2'd0,
        DSEL_INDEX = 2'd1,
        DSEL_DATA  = 2'd2
    } dsel_e;

endpackage

// File: rtl/curport_dir_decode.sv
module curport_dir_decode
    import curport_pkg::*;
#(
    parameter logic [2:0] INDEX_SLOT = 3'b100,
    parameter logic [2:0] DATA_SLOT  = 3'b101
) (
    input  logic       hi_sel,
    input  logic [1:0] addr,
    output dsel_e      dsel
);
    logic [2:0] slot;

    always_comb begin
        slot = {hi_sel, addr};
        if (slot == INDEX_SLOT)
            dsel = DSEL_INDEX;
        else if (slot == DATA_SLOT)
            dsel = DSEL_DATA;
        else
            dsel = DSEL_NONE;
    end
endmodule

// File: rtl/curport_cram_ptr.sv
module curport_cram_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          step,
    input  logic [7:0]    wdata,
    output logic [AW-1:0] ptr
);
    localparam int HI_W = AW - 8;

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ld_lo)
            ptr_d[7:0] = wdata;
        else if (ld_hi)
            ptr_d[AW-1:8] = wdata[HI_W-1:0];
        else if (step)
            ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

    assert_ptr_load_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (ptr_q[7:0] == $past(wdata)));
endmodule

// File: rtl/curport_ind_regs.sv
module curport_ind_regs
    import curport_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int HOT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  byte_t            idx,
    input  byte_t            wdata,
    output byte_t            rd_val,
    output logic             rd_hit,
    output logic             cur_en,
    output logic             cur_planar,
    output logic [POS_W-1:0] cur_x,
    output logic [POS_W-1:0] cur_y,
    output logic [HOT_W-1:0] hot_x,
    output logic [HOT_W-1:0] hot_y,
    output logic [23:0]      col0,
    output logic [23:0]      col1
);
    localparam int    PHI_W    = POS_W - 8;
    localparam int    HOT_MAX  = (1 << HOT_W) - 1;
    localparam byte_t HOT_MAX8 = 8'(HOT_MAX);

    typedef struct packed {
        logic [POS_W-1:0]                     x;
        logic [POS_W-1:0]                     y;
        logic [HOT_W-1:0]                     hx;
        logic [HOT_W-1:0]                     hy;
        logic                                 en;
        logic                                 pl;
        logic [NUM_COLOUR_BYTES-1:0][7:0]     col;
    } ind_state_t;

    ind_state_t s_d, s_q;

    function automatic logic [HOT_W-1:0] sat_hot(input byte_t v);
        return (v > HOT_MAX8) ? HOT_W'(HOT_MAX) : v[HOT_W-1:0];
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (idx)
                IX_XLO:  s_d.x[7:0]       = wdata;
                IX_XHI:  s_d.x[POS_W-1:8] = wdata[PHI_W-1:0];
                IX_YLO:  s_d.y[7:0]       = wdata;
                IX_YHI:  s_d.y[POS_W-1:8] = wdata[PHI_W-1:0];
                IX_HOTX: s_d.hx           = sat_hot(wdata);
                IX_HOTY: s_d.hy           = sat_hot(wdata);
                IX_CTRL: begin
                    s_d.en = wdata[CTRL_EN_BIT];
                    s_d.pl = wdata[CTRL_PLANAR_BIT];
                end
                default: ;
            endcase
            for (int k = 0; k < NUM_COLOUR_BYTES; k++) begin
                if (idx == IX_C0R + 8'(k))
                    s_d.col[k] = wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        rd_hit = 1'b1;
        case (idx)
            IX_XLO:  rd_val = s_q.x[7:0];
            IX_XHI:  rd_val = 8'(s_q.x[POS_W-1:8]);
            IX_YLO:  rd_val = s_q.y[7:0];
            IX_YHI:  rd_val = 8'(s_q.y[POS_W-1:8]);
            IX_HOTX: rd_val = 8'(s_q.hx);
            IX_HOTY: rd_val = 8'(s_q.hy);
            IX_CTRL: begin
                rd_val[CTRL_EN_BIT]     = s_q.en;
                rd_val[CTRL_PLANAR_BIT] = s_q.pl;
            end
            default: rd_hit = 1'b0;
        endcase
        for (int k = 0; k < NUM_COLOUR_BYTES; k++) begin
            if (idx == IX_C0R + 8'(k)) begin
                rd_val = s_q.col[k];
                rd_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cur_en     = s_q.en;
    assign cur_planar = s_q.pl;
    assign cur_x      = s_q.x;
    assign cur_y      = s_q.y;
    assign hot_x      = s_q.hx;
    assign hot_y      = s_q.hy;
    assign col0       = {s_q.col[0], s_q.col[1], s_q.col[2]};
    assign col1       = {s_q.col[3], s_q.col[4], s_q.col[5]};

    assert_ctrl_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_CTRL) |=> (cur_en == $past(wdata[CTRL_EN_BIT])));

    assert_hot_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_HOTX && wdata > HOT_MAX8) |=> (hot_x == HOT_W'(HOT_MAX)));

    assert_pos_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_hit) |=> ($stable(cur_x) && $stable(cur_y)));
endmodule

// File: rtl/curport_host_if.sv
module curport_host_if
    import curport_pkg::*;
#(
    parameter int    CRAM_AW  = 10,
    parameter int    POS_W    = 12,
    parameter int    HOT_W    = 6,
    parameter byte_t ID_VALUE = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_we,
    input  logic               host_hi_sel,
    input  logic [1:0]         host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               host_rd_valid,
    output logic               cram_we,
    output logic               cram_re,
    output logic [CRAM_AW-1:0] cram_addr,
    output logic [7:0]         cram_wdata,
    input  logic [7:0]         cram_rdata,
    output logic               cur_enable,
    output logic               cur_planar,
    output logic [POS_W-1:0]   cur_x,
    output logic [POS_W-1:0]   cur_y,
    output logic [HOT_W-1:0]   hot_x,
    output logic [HOT_W-1:0]   hot_y,
    output logic [23:0]        col0_rgb,
    output logic [23:0]        col1_rgb
);
    localparam int PTR_HI_W = CRAM_AW - 8;

    typedef struct packed {
        byte_t index;
        byte_t rdata;
        logic  rvalid;
    } top_state_t;

    top_state_t st_d, st_q;

    dsel_e               dsel;
    logic                data_acc, ind_wr, on_ram_port;
    logic                ld_lo, ld_hi, step;
    byte_t               rf_rd;
    logic                rf_hit;
    logic [CRAM_AW-1:0]  ptr;
    byte_t               rd_mux;

    curport_dir_decode u_dec (
        .hi_sel (host_hi_sel),
        .addr   (host_addr),
        .dsel   (dsel)
    );

    always_comb begin
        data_acc    = host_cs && (dsel == DSEL_DATA);
        ind_wr      = data_acc && host_we;
        on_ram_port = (st_q.index == IX_RDAT);
        ld_lo       = ind_wr && (st_q.index == IX_RAL);
        ld_hi       = ind_wr && (st_q.index == IX_RAH);
        step        = data_acc && on_ram_port;
    end

    curport_cram_ptr #(.AW(CRAM_AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .step  (step),
        .wdata (host_wdata),
        .ptr   (ptr)
    );

    curport_ind_regs #(.POS_W(POS_W), .HOT_W(HOT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ind_wr),
        .idx        (st_q.index),
        .wdata      (host_wdata),
        .rd_val     (rf_rd),
        .rd_hit     (rf_hit),
        .cur_en     (cur_enable),
        .cur_planar (cur_planar),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .hot_x      (hot_x),
        .hot_y      (hot_y),
        .col0       (col0_rgb),
        .col1       (col1_rgb)
    );

    always_comb begin
        rd_mux = '0;
        case (dsel)
            DSEL_INDEX: rd_mux = st_q.index;
            DSEL_DATA: begin
                case (st_q.index)
                    IX_RAL:  rd_mux = ptr[7:0];
                    IX_RAH:  rd_mux = 8'(ptr[CRAM_AW-1:8]);
                    IX_RDAT: rd_mux = cram_rdata;
                    IX_ID:   rd_mux = ID_VALUE;
                    default: rd_mux = rf_hit ? rf_rd : 8'h00;
                endcase
            end
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = host_cs && !host_we;
        if (host_cs && !host_we)
            st_d.rdata = rd_mux;
        if (host_cs && host_we && dsel == DSEL_INDEX)
            st_d.index = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign host_rdata    = st_q.rdata;
    assign host_rd_valid = st_q.rvalid;
    assign cram_we       = ind_wr && on_ram_port;
    assign cram_re       = data_acc && !host_we && on_ram_port;
    assign cram_addr     = ptr;
    assign cram_wdata    = host_wdata;

    assert_rvalid_after_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we) |=> host_rd_valid);

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cs && !host_we) |=> $stable(host_rdata));

    assert_ramwe_from_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> (host_cs && host_we && !cram_re));

    assert_index_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_we && {host_hi_sel, host_addr} == 3'b100)
            |=> (st_q.index == $past(host_wdata)));
endmodule

// File: tb/tb_curport_host_if.sv
module tb_curport_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_we = 1'b0, host_hi_sel = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rd_valid;
    logic        cram_we, cram_re;
    logic [9:0]  cram_addr;
    logic [7:0]  cram_wdata, cram_rdata;
    logic        cur_enable, cur_planar;
    logic [11:0] cur_x, cur_y;
    logic [5:0]  hot_x, hot_y;
    logic [23:0] col0_rgb, col1_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] ram [1024];

    always #5 clk = ~clk;

    curport_host_if dut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_hi_sel(host_hi_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rd_valid(host_rd_valid),
        .cram_we(cram_we), .cram_re(cram_re), .cram_addr(cram_addr),
        .cram_wdata(cram_wdata), .cram_rdata(cram_rdata),
        .cur_enable(cur_enable), .cur_planar(cur_planar), .cur_x(cur_x), .cur_y(cur_y),
        .hot_x(hot_x), .hot_y(hot_y), .col0_rgb(col0_rgb), .col1_rgb(col1_rgb)
    );

    // pattern RAM model: asynchronous read, synchronous write
    always @(posedge clk) if (cram_we) ram[cram_addr] <= cram_wdata;
    assign cram_rdata = ram[cram_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic hi, input logic [1:0] a, input logic we, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_hi_sel = hi; host_addr = a; host_we = we; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic hi, input logic [1:0] a, input logic [7:0] d);
        acc(hi, a, 1'b1, d);
    endtask

    task automatic rd(input logic hi, input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        acc(hi, a, 1'b0, 8'h00);
    endtask

    task automatic ind_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b1, 2'd0, idx);
        wr(1'b1, 2'd1, d);
    endtask

    task automatic ind_rd(input logic [7:0] idx, input logic [7:0] e, input string tag);
        wr(1'b1, 2'd0, idx);
        rd(1'b1, 2'd1, e, tag);
    endtask

    // data-port write with same-cycle strobe check (index must already be 0x12)
    task automatic ram_wr_chk(input logic [7:0] d, input logic [9:0] ea);
        @(negedge clk);
        host_cs = 1'b1; host_hi_sel = 1'b1; host_addr = 2'd1; host_we = 1'b1; host_wdata = d;
        #1;
        check(cram_we === 1'b1, "R10 cram_we", int'(cram_we), 1);
        check(cram_addr === ea, "R10 cram_addr", int'(cram_addr), int'(ea));
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    // monitor: scoreboard compare of read results
    always @(negedge clk) begin
        if (rst_n && host_rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected read valid", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata === e, t, int'(host_rdata), int'(e));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_rd_valid === 1'b0 && cram_we === 1'b0 && cram_re === 1'b0, "R1 strobes", 0, 0);
        check(cur_x === 12'h0 && cur_y === 12'h0 && cur_enable === 1'b0, "R1 regs", int'(cur_x), 0);
        check(cram_addr === 10'h0, "R1 pointer", int'(cram_addr), 0);

        // R3 index readback
        wr(1'b1, 2'd0, 8'hA7);
        rd(1'b1, 2'd0, 8'hA7, "R3 index readback");

        // R2 unused direct slots
        wr(1'b1, 2'd0, 8'h55);
        wr(1'b0, 2'd0, 8'h99);
        wr(1'b1, 2'd2, 8'h99);
        wr(1'b1, 2'd3, 8'h99);
        rd(1'b0, 2'd0, 8'h00, "R2 slot 000 reads zero");
        rd(1'b1, 2'd3, 8'h00, "R2 slot 111 reads zero");
        rd(1'b1, 2'd0, 8'h55, "R2 index unaffected");

        // R5 position (and R4 indirect path)
        ind_wr(8'h00, 8'hBC);
        ind_wr(8'h01, 8'hFA);
        ind_wr(8'h02, 8'h23);
        ind_wr(8'h03, 8'h01);
        check(cur_x === 12'hABC, "R5 cur_x", int'(cur_x), 'hABC);
        check(cur_y === 12'h123, "R5 cur_y", int'(cur_y), 'h123);
        ind_rd(8'h01, 8'h0A, "R5 X high readback");
        ind_rd(8'h00, 8'hBC, "R4 X low readback");

        // R6 hotspot
        ind_wr(8'h04, 8'd40);
        ind_wr(8'h05, 8'd200);
        check(hot_x === 6'd40, "R6 hot_x", int'(hot_x), 40);
        check(hot_y === 6'd63, "R6 hot_y saturated", int'(hot_y), 63);
        ind_rd(8'h05, 8'd63, "R6 hot_y readback");

        // R7 control
        ind_wr(8'h06, 8'hFF);
        check(cur_enable === 1'b1 && cur_planar === 1'b1, "R7 control set", int'({cur_planar, cur_enable}), 3);
        ind_rd(8'h06, 8'h81, "R7 control readback");
        ind_wr(8'h06, 8'h80);
        check(cur_enable === 1'b0 && cur_planar === 1'b1, "R7 enable off", int'({cur_planar, cur_enable}), 2);

        // R8 colours
        for (int k = 0; k < 6; k++) ind_wr(8'h08 + 8'(k), 8'h10 + 8'(k));
        check(col0_rgb === 24'h101112, "R8 colour 0", int'(col0_rgb), 'h101112);
        check(col1_rgb === 24'h131415, "R8 colour 1", int'(col1_rgb), 'h131415);
        ind_rd(8'h0C, 8'h14, "R8 colour 1 green");

        // R9 address setup, R10 streaming writes with wrap
        ind_wr(8'h10, 8'hFE);
        ind_wr(8'h11, 8'h03);
        ind_rd(8'h11, 8'h03, "R9 address high");
        ind_rd(8'h10, 8'hFE, "R9 address low");
        wr(1'b1, 2'd0, 8'h12);
        ram_wr_chk(8'h11, 10'd1022);
        ram_wr_chk(8'h22, 10'd1023);
        ram_wr_chk(8'h33, 10'd0);
        ind_rd(8'h10, 8'h01, "R10 pointer wrapped to 1");

        // R11 streaming reads
        ind_wr(8'h10, 8'hFF);
        ind_wr(8'h11, 8'h03);
        wr(1'b1, 2'd0, 8'h12);
        rd(1'b1, 2'd1, 8'h22, "R11 read at 1023");
        rd(1'b1, 2'd1, 8'h33, "R11 read at 0");
        ind_rd(8'h10, 8'h01, "R11 pointer advanced");

        // R12 unmapped and identity entries
        ind_wr(8'h30, 8'h77);
        ind_wr(8'h07, 8'h77);
        ind_rd(8'h30, 8'h00, "R12 unmapped reads zero");
        ind_rd(8'h07, 8'h00, "R12 gap reads zero");
        check(cur_x === 12'hABC && cur_y === 12'h123, "R12 position untouched", int'(cur_x), 'hABC);
        ind_wr(8'hFF, 8'h00);
        ind_rd(8'hFF, 8'h5A, "R12 identity constant");

        // R13 hold after read
        repeat (3) @(negedge clk);
        check(host_rd_valid === 1'b0, "R13 valid one cycle", int'(host_rd_valid), 0);
        check(host_rdata === 8'h5A, "R13 rdata holds", int'(host_rdata), 'h5A);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R13 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule